// File: doc/BRIEF.md
# Discrete-Input Sensor SPI Register Slave

This block is the serial register front end of a 32-channel discrete-input sensing device. A host reaches it over a four-wire SPI link in mode 0. The system clock oversamples the link, so SCLK, CS_N and MOSI are first brought through a short synchronizer. Every frame opens with one command byte. Its top bit chooses read or write, and its lower seven bits name a register. The bytes that follow carry either the write data or the returned read data.

The register set has four parts. A control register holds a test-mode bit and a software reset bit. A sensing-mode register holds one bit per bank of eight channels. Two 16-bit threshold words serve the two sensing modes. A status window shows the live channel levels. The master sets the width of a read by the number of bytes it clocks after the command. The same address can therefore return one, two or four bytes, always most significant byte first. The status window can be read one byte at a time, or all 32 bits at once through an alias. Register contents go out on ports to the detection logic, and channel levels come in on a port.

Top module: `dsi_spi_regs`

## Requirements
- R1: A frame is the bytes sent while `cs_n` is low. Its first byte is the command: bit 7 = 1 reads, bit 7 = 0 writes, and bits 6:0 give the address. MOSI is sampled on the rising SCLK edge, MISO changes only after a falling SCLK edge, and each byte travels MSB first.
- R2: Read data follows the command MSB first. A byte-wide register is the first byte. A threshold word is two bytes, high byte first. Every byte clocked past the register's width reads 0x00.
- R3: A byte write is a 2-byte frame. At 0x02 (control), bit 0 is test mode and bit 1 is software reset; other bits are dropped and read as 0. At 0x04 (sensing mode), bit n selects the mode of channels 8n..8n+7; bits 7:4 are dropped and read as 0.
- R4: A threshold write is command, high byte, low byte. 0x3A is the ground-open word and 0x3C is the supply-open word. The word changes only once the low byte completes. A frame that ends after the high byte leaves it unchanged.
- R5: 0x10, 0x12, 0x14 and 0x16 return `chan_status` bits 7:0, 15:8, 23:16 and 31:24. 0x78 returns all 32 bits, bits 31:24 first. The value is captured when the command byte completes.
- R6: A read of an unmapped address returns 0x00. A write to an unmapped address or a status address changes no register.
- R7: While control bit 1 is set, the sensing-mode register, both threshold words and the test bit are held at zero, and writes to them are dropped. The control register itself stays writable.
- R8: Driving `rst_n` low zeroes every register and ends any frame in progress.
- R9: Raising `cs_n` mid-byte discards the partial byte. The next frame starts afresh with a command byte.
- R10: `test_mode`, `bank_mode`, `thr_gnd_open` and `thr_sup_open` show the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCLK |
| rst_n | input | 1 | Active-low hardware reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| chan_status | input | 32 | Live channel levels |
| test_mode | output | 1 | Control test bit |
| bank_mode | output | 4 | Sensing mode per bank of eight channels |
| thr_gnd_open | output | 16 | Ground-open threshold word |
| thr_sup_open | output | 16 | Supply-open threshold word |

## Verification
A bit counter that slips, or a byte index that is not cleared, shows up within the next frame. Read data on MISO comes back shifted by one bit position, or lands in the wrong byte of a multi-byte read. A register that takes a write it should drop, whether from a status address, an unmapped address, an aborted byte or a half-finished threshold frame, is seen on the export ports a few system clocks after `cs_n` rises, and again on the next read-back. A software reset that fails to hold its registers shows directly on `bank_mode` and the threshold ports.

// File: rtl/spirb_pkg.sv
package spirb_pkg;
   localparam int WORD_W     = 32;
   localparam int BYTE_W     = 8;
   localparam int CMD_RD_BIT = 7;

   localparam logic [6:0] ADR_CTRL    = 7'h02;
   localparam logic [6:0] ADR_MODE    = 7'h04;
   localparam logic [6:0] ADR_STS_B0  = 7'h10;
   localparam logic [6:0] ADR_STS_B1  = 7'h12;
   localparam logic [6:0] ADR_STS_B2  = 7'h14;
   localparam logic [6:0] ADR_STS_B3  = 7'h16;
   localparam logic [6:0] ADR_THR_GO  = 7'h3A;
   localparam logic [6:0] ADR_THR_SO  = 7'h3C;
   localparam logic [6:0] ADR_STS_ALL = 7'h78;

   typedef enum logic [2:0] {
      K_NONE, K_CTRL, K_MODE, K_THR_GO, K_THR_SO, K_STS_BYTE, K_STS_ALL
   } reg_kind_e;

   function automatic reg_kind_e kind_of(input logic [6:0] adr);
      case (adr)
         ADR_CTRL:    kind_of = K_CTRL;
         ADR_MODE:    kind_of = K_MODE;
         ADR_THR_GO:  kind_of = K_THR_GO;
         ADR_THR_SO:  kind_of = K_THR_SO;
         ADR_STS_B0, ADR_STS_B1, ADR_STS_B2, ADR_STS_B3:
                      kind_of = K_STS_BYTE;
         ADR_STS_ALL: kind_of = K_STS_ALL;
         default:     kind_of = K_NONE;
      endcase
   endfunction
endpackage

// File: rtl/spirb_sync.sv
module spirb_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spirb_sync needs at least two stages");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spirb_shifter.sv
module spirb_shifter
   import spirb_pkg::*;
#(
   parameter int TX_W    = WORD_W,
   parameter int IDX_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              cs_n_s,
   input  logic              mosi_s,
   input  logic              load_en,
   input  logic [TX_W-1:0]   load_word,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] rx_byte,
   output logic [IDX_W-1:0]  byte_idx,
   output logic              miso
);
   localparam int CNT_W = $clog2(BYTE_W);

   if (TX_W % BYTE_W != 0) begin : g_bad_txw
      $error("TX_W must be a whole number of bytes");
   end

   logic              sclk_d;
   logic              sclk_rise, sclk_fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [IDX_W-1:0]  byte_cnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [TX_W-1:0]   tx_sh;
   logic              hold;

   assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
   assign sclk_fall = ~sclk_s & sclk_d & ~cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         byte_cnt   <= '0;
         rx_sh      <= '0;
         rx_byte    <= '0;
         byte_idx   <= '0;
         byte_valid <= 1'b0;
      end else if (cs_n_s) begin
         bit_cnt    <= '0;
         byte_cnt   <= '0;
         rx_sh      <= '0;
         byte_valid <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         if (sclk_rise) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(BYTE_W-1)) begin
               byte_valid <= 1'b1;
               rx_byte    <= {rx_sh[BYTE_W-2:0], mosi_s};
               byte_idx   <= byte_cnt;
               if (byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
            end
         end
      end
   end

   // the word loaded after the command must survive the falling edge that ends it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
         hold  <= 1'b0;
      end else if (cs_n_s) begin
         tx_sh <= '0;
         hold  <= 1'b0;
      end else if (load_en) begin
         tx_sh <= load_word;
         hold  <= 1'b1;
      end else if (sclk_fall) begin
         if (hold) hold  <= 1'b0;
         else      tx_sh <= {tx_sh[TX_W-2:0], 1'b0};
      end
   end

   assign miso = tx_sh[TX_W-1];

   a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (bit_cnt == '0 && byte_cnt == '0 && !byte_valid));

   a_r1_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(miso) |-> $past(sclk_fall || load_en || cs_n_s));
endmodule

// File: rtl/spirb_regfile.sv
module spirb_regfile
   import spirb_pkg::*;
#(
   parameter int NUM_CH  = 32,
   parameter int BANK_SZ = 8,
   parameter int THR_W   = 16,
   parameter int IDX_W   = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          byte_valid,
   input  logic [BYTE_W-1:0]             rx_byte,
   input  logic [IDX_W-1:0]              byte_idx,
   input  logic [NUM_CH-1:0]             chan_status,
   output logic                          load_en,
   output logic [WORD_W-1:0]             load_word,
   output logic                          test_mode,
   output logic [NUM_CH/BANK_SZ-1:0]     bank_mode,
   output logic [THR_W-1:0]              thr_go,
   output logic [THR_W-1:0]              thr_so
);
   localparam int NUM_BANKS = NUM_CH / BANK_SZ;

   if (NUM_CH % BANK_SZ != 0 || NUM_CH > WORD_W) begin : g_bad_ch
      $error("NUM_CH must be a multiple of BANK_SZ and fit the status word");
   end
   if (NUM_BANKS > BYTE_W) begin : g_bad_banks
      $error("sensing-mode banks must fit one byte");
   end
   if (THR_W != 2 * BYTE_W) begin : g_bad_thr
      $error("threshold words are carried as two bytes");
   end

   logic [BYTE_W-1:0]    cmd_q, hi_q;
   logic [1:0]           ctrl_q;
   logic [NUM_BANKS-1:0] mode_q;
   logic [THR_W-1:0]     thr_go_q, thr_so_q;
   logic [WORD_W-1:0]    sts_word;
   reg_kind_e            kind_q, kind_new;
   logic                 wr_byte, wr_lo, srst_q;

   assign kind_q   = kind_of(cmd_q[6:0]);
   assign kind_new = kind_of(rx_byte[6:0]);
   assign srst_q   = ctrl_q[1];
   assign wr_byte  = byte_valid && !cmd_q[CMD_RD_BIT] && byte_idx == IDX_W'(1);
   assign wr_lo    = byte_valid && !cmd_q[CMD_RD_BIT] && byte_idx == IDX_W'(2);
   assign load_en  = byte_valid && byte_idx == '0 && rx_byte[CMD_RD_BIT];

   always_comb begin
      sts_word = '0;
      sts_word[NUM_CH-1:0] = chan_status;
   end

   always_comb begin
      load_word = '0;
      case (kind_new)
         K_CTRL:     load_word[WORD_W-1 -: BYTE_W] = BYTE_W'(ctrl_q);
         K_MODE:     load_word[WORD_W-1 -: BYTE_W] = BYTE_W'(mode_q);
         K_THR_GO:   load_word[WORD_W-1 -: THR_W]  = thr_go_q;
         K_THR_SO:   load_word[WORD_W-1 -: THR_W]  = thr_so_q;
         K_STS_BYTE: load_word[WORD_W-1 -: BYTE_W] = sts_word[BYTE_W*rx_byte[2:1] +: BYTE_W];
         K_STS_ALL:  load_word = sts_word;
         default:    load_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         hi_q     <= '0;
         ctrl_q   <= '0;
         mode_q   <= '0;
         thr_go_q <= '0;
         thr_so_q <= '0;
      end else begin
         if (byte_valid && byte_idx == '0) cmd_q <= rx_byte;
         if (wr_byte) hi_q <= rx_byte;
         if (wr_byte && kind_q == K_CTRL)
            ctrl_q <= {rx_byte[1], rx_byte[0] & ~rx_byte[1]};
         if (srst_q) begin
            mode_q   <= '0;
            thr_go_q <= '0;
            thr_so_q <= '0;
         end else begin
            if (wr_byte && kind_q == K_MODE)  mode_q   <= rx_byte[NUM_BANKS-1:0];
            if (wr_lo && kind_q == K_THR_GO)  thr_go_q <= {hi_q, rx_byte};
            if (wr_lo && kind_q == K_THR_SO)  thr_so_q <= {hi_q, rx_byte};
         end
      end
   end

   assign test_mode = ctrl_q[0];
   assign bank_mode = mode_q;
   assign thr_go    = thr_go_q;
   assign thr_so    = thr_so_q;

   a_r7_srst_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> (mode_q == '0 && thr_go_q == '0 && thr_so_q == '0));

   a_r4_thr_needs_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_lo && kind_q == K_THR_GO) && !srst_q) |=> $stable(thr_go_q));

   a_r6_status_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_byte && (kind_q == K_STS_BYTE || kind_q == K_STS_ALL || kind_q == K_NONE))
      |=> ($stable(ctrl_q) && $stable(mode_q)));

   a_r7_test_cleared_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |-> !test_mode);
endmodule

// File: rtl/dsi_spi_regs.sv
module dsi_spi_regs
   import spirb_pkg::*;
#(
   parameter int NUM_CH      = 32,
   parameter int BANK_SZ     = 8,
   parameter int THR_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int IDX_W       = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sclk,
   input  logic                      cs_n,
   input  logic                      mosi,
   output logic                      miso,
   input  logic [NUM_CH-1:0]         chan_status,
   output logic                      test_mode,
   output logic [NUM_CH/BANK_SZ-1:0] bank_mode,
   output logic [THR_W-1:0]          thr_gnd_open,
   output logic [THR_W-1:0]          thr_sup_open
);
   logic [2:0]        pins_s;
   logic              load_en, byte_valid;
   logic [WORD_W-1:0] load_word;
   logic [BYTE_W-1:0] rx_byte;
   logic [IDX_W-1:0]  byte_idx;

   spirb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, mosi}), .q(pins_s));

   spirb_shifter #(.TX_W(WORD_W), .IDX_W(IDX_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(pins_s[2]), .cs_n_s(pins_s[1]), .mosi_s(pins_s[0]),
      .load_en(load_en), .load_word(load_word),
      .byte_valid(byte_valid), .rx_byte(rx_byte), .byte_idx(byte_idx),
      .miso(miso));

   spirb_regfile #(.NUM_CH(NUM_CH), .BANK_SZ(BANK_SZ), .THR_W(THR_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .byte_valid(byte_valid), .rx_byte(rx_byte), .byte_idx(byte_idx),
      .chan_status(chan_status),
      .load_en(load_en), .load_word(load_word),
      .test_mode(test_mode), .bank_mode(bank_mode),
      .thr_go(thr_gnd_open), .thr_so(thr_sup_open));
endmodule

// File: tb/sim_dsi_spi_regs.sv
module sim_dsi_spi_regs;
   localparam int HP = 8;
   localparam int NV = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic        miso;
   logic [31:0] chan_status = 32'hA1B2C3D4;
   logic        test_mode;
   logic [3:0]  bank_mode;
   logic [15:0] thr_gnd_open, thr_sup_open;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   dsi_spi_regs u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
      .chan_status(chan_status), .test_mode(test_mode), .bank_mode(bank_mode),
      .thr_gnd_open(thr_gnd_open), .thr_sup_open(thr_sup_open));

   // {cmd, data byte count, write data left-aligned, expected read left-aligned}
   localparam logic [79:0] VEC [NV] = '{
      {8'h04, 8'd1, 32'h05000000, 32'h00000000},
      {8'h84, 8'd1, 32'h00000000, 32'h05000000},
      {8'h84, 8'd4, 32'h00000000, 32'h05000000},
      {8'h3A, 8'd2, 32'h12340000, 32'h00000000},
      {8'hBA, 8'd2, 32'h00000000, 32'h12340000},
      {8'h3C, 8'd2, 32'hABCD0000, 32'h00000000},
      {8'hBC, 8'd2, 32'h00000000, 32'hABCD0000},
      {8'hBA, 8'd1, 32'h00000000, 32'h12000000},
      {8'h02, 8'd1, 32'h01000000, 32'h00000000},
      {8'h82, 8'd1, 32'h00000000, 32'h01000000},
      {8'h85, 8'd1, 32'h00000000, 32'h00000000},
      {8'h05, 8'd1, 32'hFF000000, 32'h00000000},
      {8'h84, 8'd1, 32'h00000000, 32'h05000000},
      {8'h90, 8'd1, 32'h00000000, 32'hD4000000},
      {8'h92, 8'd1, 32'h00000000, 32'hC3000000},
      {8'h94, 8'd1, 32'h00000000, 32'hB2000000},
      {8'h96, 8'd1, 32'h00000000, 32'hA1000000},
      {8'hF8, 8'd4, 32'h00000000, 32'hA1B2C3D4},
      {8'h10, 8'd1, 32'h55000000, 32'h00000000},
      {8'h90, 8'd1, 32'h00000000, 32'hD4000000},
      {8'h04, 8'd1, 32'hFF000000, 32'h00000000},
      {8'h84, 8'd1, 32'h00000000, 32'h0F000000},
      {8'h02, 8'd1, 32'hFD000000, 32'h00000000},
      {8'h82, 8'd1, 32'h00000000, 32'h01000000}
   };

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic spi_bit(input logic b, output logic r);
      mosi = b;
      wait_clk(HP);
      r = miso;
      sclk = 1'b1;
      wait_clk(HP);
      sclk = 1'b0;
   endtask

   task automatic frame(input logic [7:0] cmd, input int n, input logic [31:0] wd,
                        output logic [31:0] rd);
      logic [7:0] tx;
      logic       r;
      rd = '0;
      cs_n = 1'b0;
      wait_clk(HP);
      for (int b = 0; b <= n; b++) begin
         tx = (b == 0) ? cmd : wd[31 - 8*(b-1) -: 8];
         for (int i = 7; i >= 0; i--) begin
            spi_bit(tx[i], r);
            if (b > 0) rd[31 - 8*(b-1) - (7-i)] = r;
         end
      end
      wait_clk(HP);
      cs_n = 1'b1;
      wait_clk(4*HP);
   endtask

   task automatic partial(input logic [7:0] first, input int nbits_cmd,
                          input logic [7:0] second, input int nbits_data);
      logic r;
      cs_n = 1'b0;
      wait_clk(HP);
      for (int i = 7; i > 7 - nbits_cmd; i--) spi_bit(first[i], r);
      for (int i = 7; i > 7 - nbits_data; i--) spi_bit(second[i], r);
      wait_clk(HP);
      cs_n = 1'b1;
      wait_clk(4*HP);
   endtask

   function automatic string req_of(input logic [7:0] cmd);
      case (cmd[6:0])
         7'h10, 7'h12, 7'h14, 7'h16, 7'h78: req_of = "R5 status";
         7'h02, 7'h04, 7'h3A, 7'h3C:        req_of = "R2 read-back";
         default:                           req_of = "R6 unmapped";
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R8 / R10: reset state at the ports
      check("R8 reset bank_mode", 32'(bank_mode), 32'h0);
      check("R8 reset thresholds", {thr_gnd_open, thr_sup_open}, 32'h0);
      check("R8 reset test_mode", 32'(test_mode), 32'h0);
      check("R1 miso idle", 32'(miso), 32'h0);

      // vector table: R1, R2, R3, R5, R6 through write/read-back
      for (int v = 0; v < NV; v++) begin
         frame(VEC[v][79:72], int'(VEC[v][71:64]), VEC[v][63:32], rd);
         if (VEC[v][79])
            check($sformatf("%s vec %0d", req_of(VEC[v][79:72]), v), rd, VEC[v][31:0]);
      end

      // R10: export ports follow the stored registers
      check("R10 bank_mode", 32'(bank_mode), 32'hF);
      check("R10 thr_gnd_open", 32'(thr_gnd_open), 32'h1234);
      check("R10 thr_sup_open", 32'(thr_sup_open), 32'hABCD);
      check("R10 test_mode", 32'(test_mode), 32'h1);

      // R4: half threshold frame is dropped
      frame(8'h3A, 2, 32'h55660000, rd);
      frame(8'h3A, 1, 32'h77000000, rd);
      frame(8'hBA, 2, 32'h0, rd);
      check("R4 partial threshold", rd, 32'h55660000);
      check("R4 port after partial", 32'(thr_gnd_open), 32'h5566);

      // R7: software reset
      frame(8'h02, 1, 32'h02000000, rd);
      check("R7 srst bank_mode", 32'(bank_mode), 32'h0);
      check("R7 srst thresholds", {thr_gnd_open, thr_sup_open}, 32'h0);
      check("R7 srst test_mode", 32'(test_mode), 32'h0);
      frame(8'h04, 1, 32'h03000000, rd);
      frame(8'h84, 1, 32'h0, rd);
      check("R7 write blocked", rd, 32'h0);
      frame(8'h82, 1, 32'h0, rd);
      check("R7 ctrl readable", rd, 32'h02000000);
      frame(8'h02, 1, 32'h00000000, rd);
      frame(8'h04, 1, 32'h03000000, rd);
      frame(8'h84, 1, 32'h0, rd);
      check("R7 released", rd, 32'h03000000);

      // R9: aborts
      partial(8'h04, 8, 8'hFF, 4);
      check("R9 aborted data byte", 32'(bank_mode), 32'h3);
      partial(8'h84, 5, 8'h00, 0);
      frame(8'h04, 1, 32'h09000000, rd);
      check("R9 frame after aborted command", 32'(bank_mode), 32'h9);

      // R5: snapshot reflects new input
      chan_status = 32'h0F1E2D3C;
      wait_clk(4);
      frame(8'hF8, 4, 32'h0, rd);
      check("R5 alias new value", rd, 32'h0F1E2D3C);

      // R8: hardware reset mid-operation
      frame(8'h3C, 2, 32'h4242_0000, rd);
      rst_n = 1'b0;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(5);
      check("R8 hw reset mode", 32'(bank_mode), 32'h0);
      check("R8 hw reset thr", {thr_gnd_open, thr_sup_open}, 32'h0);
      frame(8'hBC, 2, 32'h0, rd);
      check("R8 read after hw reset", rd, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule